// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for the indexed addressing forms of a small 8/16-bit processor. A request names a base register (X, Y, stack pointer or program counter), an addressing form and an offset field; the block adds the offset to the base, or adjusts the base by a small step, or reads a 16-bit pointer from memory. It returns the effective address together with the updated base register value and a write-back flag. Because the block returns both values, load-effective-address instructions can use it as well as data accesses. Opcode decoding and the final data fetch belong to the surrounding core.

Requests enter on a valid/ready channel. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result leaves on a second valid/ready channel. Once `res_valid` rises, it stays high and every result field stays constant until an edge where `res_ready` is high. The core may therefore stall the result for as long as it needs. Indirect forms use a byte-wide memory read channel. An address is offered with `mem_req_valid` and is held until `mem_req_ready` is high. Each accepted read is answered later by a single `mem_rsp_valid` pulse carrying `mem_rsp_data`.

Top module: `idx_ea_gen`

## Requirements
- R1: Mode code 0 sign-extends `req_offset[4:0]` and adds it to the base. With X=$1234, offset 10 gives $123E, and offset field $10 gives -16.
- R2: Mode code 1 sign-extends `req_offset[8:0]`, giving a range of -256 to +255, and adds it to the base.
- R3: Mode code 2 adds the full 16-bit `req_offset` to the base, and all address arithmetic wraps modulo 2^16. With SP=$0A00, an offset of -10 gives $09F6.
- R4: The pre forms use mode code 3 to increment and mode code 4 to decrement. They adjust the base by a step n = `req_offset[2:0]`+1, which ranges from 1 to 8. The adjusted value is both the effective address and `res_base`, and `res_base_wr` is 1.
- R5: The post forms use mode code 5 to increment and mode code 6 to decrement. The unadjusted base is the effective address, `res_base` is the base adjusted by n, and `res_base_wr` is 1.
- R6: Mode codes 7, 8 and 9 add A, B or the pair A:B (A in the high byte) to the base as an unsigned value. A and B are zero-extended.
- R7: Mode code 10 forms a pointer address from base + `req_offset` (16-bit). Mode code 11 forms it from base + A:B. The block reads the byte at the pointer address as the high byte and the byte at the pointer address + 1 as the low byte, and the 16-bit pointer they form is the effective address.
- R8: Mode codes 12 to 15 are illegal. The effective address equals the base, `res_base` equals the base, `res_err` is 1 and `res_base_wr` is 0.
- R9: For every form other than R4 and R5, `res_base` equals the base and `res_base_wr` is 0. Every legal form returns `res_err` = 0.
- R10: `req_base_sel` picks the base register: 0 selects X, 1 selects Y, 2 selects SP and 3 selects PC.
- R11: A non-indirect result is valid in the cycle after acceptance. While `res_valid` is high, `req_ready` is low. The result is held unchanged until it is taken with `res_ready`.
- R12: A memory read address is held stable while `mem_req_valid` is high and `mem_req_ready` is low. No memory read is made for non-indirect forms.
- R13: After reset, `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request (idle) |
| req_mode | input | 4 | Addressing form code |
| req_base_sel | input | 2 | Base register select |
| req_offset | input | 16 | Constant offset, or step code in bits 2:0 |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| res_valid | output | 1 | A result is available |
| res_ready | input | 1 | The consumer takes the result |
| res_ea | output | 16 | Effective address |
| res_base | output | 16 | Updated base register value |
| res_base_wr | output | 1 | The base register must be written back |
| res_err | output | 1 | Illegal mode code |
| mem_req_valid | output | 1 | Memory byte read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 16 | Memory byte address |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 8 | Read data byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit memory byte, a 5-bit short offset, a 9-bit medium offset and a 3-bit step code. These parameters make both offset sign boundaries reachable with small constants. They also make the modulo-2^16 wrap of both the sum and the second pointer byte reachable, because the PC base at $C000 lies near the top of the address space. The memory model in the bench withdraws its ready on alternate cycles. This tests that the pointer read holds its address under back-pressure, and the bench also delays taking each result to test that the result stays held.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_CS      = 4'd0,
    M_CM      = 4'd1,
    M_CL      = 4'd2,
    M_PRE_UP  = 4'd3,
    M_PRE_DN  = 4'd4,
    M_POST_UP = 4'd5,
    M_POST_DN = 4'd6,
    M_ACC_LO  = 4'd7,
    M_ACC_HI  = 4'd8,
    M_ACC_W   = 4'd9,
    M_IND_C   = 4'd10,
    M_IND_W   = 4'd11
  } ea_mode_e;

  typedef enum logic [1:0] {
    B_X  = 2'd0,
    B_Y  = 2'd1,
    B_SP = 2'd2,
    B_PC = 2'd3
  } base_sel_e;
endpackage

// File: rtl/ea_offset.sv
module ea_offset
  import ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int SHORT_W = 5,
  parameter int MID_W   = 9,
  parameter int STEP_W  = 3
) (
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] offset_i,
  input  logic [DW-1:0] acc_a_i,
  input  logic [DW-1:0] acc_b_i,
  output logic [AW-1:0] off_o,
  output logic [AW-1:0] step_o,
  output logic          adj_o,
  output logic          adj_up_o,
  output logic          adj_pre_o,
  output logic          ind_o,
  output logic          bad_o
);
  localparam int ACC_PAD = AW - DW;

  logic [AW-1:0] off_short, off_mid, acc_pair;

  assign off_short = {{(AW-SHORT_W){offset_i[SHORT_W-1]}}, offset_i[SHORT_W-1:0]};
  assign off_mid   = {{(AW-MID_W){offset_i[MID_W-1]}}, offset_i[MID_W-1:0]};
  assign acc_pair  = {acc_a_i, acc_b_i};
  assign step_o    = {{(AW-STEP_W){1'b0}}, offset_i[STEP_W-1:0]} + {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    off_o     = '0;
    adj_o     = 1'b0;
    adj_up_o  = 1'b0;
    adj_pre_o = 1'b0;
    ind_o     = 1'b0;
    bad_o     = 1'b0;
    case (mode_i)
      M_CS:      off_o = off_short;
      M_CM:      off_o = off_mid;
      M_CL:      off_o = offset_i;
      M_PRE_UP:  begin adj_o = 1'b1; adj_up_o = 1'b1; adj_pre_o = 1'b1; end
      M_PRE_DN:  begin adj_o = 1'b1; adj_pre_o = 1'b1; end
      M_POST_UP: begin adj_o = 1'b1; adj_up_o = 1'b1; end
      M_POST_DN: adj_o = 1'b1;
      M_ACC_LO:  off_o = {{ACC_PAD{1'b0}}, acc_a_i};
      M_ACC_HI:  off_o = {{ACC_PAD{1'b0}}, acc_b_i};
      M_ACC_W:   off_o = acc_pair;
      M_IND_C:   begin off_o = offset_i; ind_o = 1'b1; end
      M_IND_W:   begin off_o = acc_pair; ind_o = 1'b1; end
      default:   bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] step_i,
  input  logic          adj_i,
  input  logic          adj_up_i,
  input  logic          adj_pre_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] base_o,
  output logic          wr_o
);
  logic [AW-1:0] base, sum, adjusted;

  always_comb begin
    case (sel_i)
      B_X:     base = x_i;
      B_Y:     base = y_i;
      B_SP:    base = sp_i;
      default: base = pc_i;
    endcase
  end

  assign sum      = base + off_i;
  assign adjusted = adj_up_i ? (base + step_i) : (base - step_i);

  always_comb begin
    if (adj_i) begin
      ea_o   = adj_pre_i ? adjusted : base;
      base_o = adjusted;
      wr_o   = 1'b1;
    end else begin
      ea_o   = sum;
      base_o = base;
      wr_o   = 1'b0;
    end
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          done_o,
  output logic [AW-1:0] ptr_o,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  typedef enum logic [2:0] {PF_IDLE, PF_REQ_HI, PF_WAIT_HI, PF_REQ_LO, PF_WAIT_LO} pf_state_e;

  pf_state_e     st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] hi_q;

  assign mem_req_valid = (st == PF_REQ_HI) || (st == PF_REQ_LO);
  assign mem_addr      = (st == PF_REQ_LO) ? (addr_q + {{(AW-1){1'b0}}, 1'b1}) : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PF_IDLE;
      addr_q <= '0;
      hi_q   <= '0;
      ptr_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        PF_IDLE:    if (start_i) begin addr_q <= addr_i; st <= PF_REQ_HI; end
        PF_REQ_HI:  if (mem_req_ready) st <= PF_WAIT_HI;
        PF_WAIT_HI: if (mem_rsp_valid) begin hi_q <= mem_rsp_data; st <= PF_REQ_LO; end
        PF_REQ_LO:  if (mem_req_ready) st <= PF_WAIT_LO;
        PF_WAIT_LO: if (mem_rsp_valid) begin
          ptr_o  <= {hi_q, mem_rsp_data};
          done_o <= 1'b1;
          st     <= PF_IDLE;
        end
        default:    st <= PF_IDLE;
      endcase
    end
  end

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  p_lo_follows_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_REQ_LO) |-> (mem_addr == addr_q + {{(AW-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int SHORT_W = 5,
  parameter int MID_W   = 9,
  parameter int STEP_W  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic [1:0]    req_base_sel,
  input  logic [AW-1:0] req_offset,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_ea,
  output logic [AW-1:0] res_base,
  output logic          res_base_wr,
  output logic          res_err,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  typedef enum logic [1:0] {T_IDLE, T_IND, T_DONE} top_state_e;

  top_state_e    st;
  logic [AW-1:0] off, step, ea_c, base_c, ptr;
  logic          adj, adj_up, adj_pre, ind, bad, wr_c, pf_done, accept;

  ea_offset #(.AW(AW), .DW(DW), .SHORT_W(SHORT_W), .MID_W(MID_W), .STEP_W(STEP_W)) u_off (
    .mode_i(req_mode), .offset_i(req_offset), .acc_a_i(acc_a), .acc_b_i(acc_b),
    .off_o(off), .step_o(step), .adj_o(adj), .adj_up_o(adj_up), .adj_pre_o(adj_pre),
    .ind_o(ind), .bad_o(bad)
  );

  ea_adder #(.AW(AW)) u_add (
    .sel_i(req_base_sel), .x_i(reg_x), .y_i(reg_y), .sp_i(reg_sp), .pc_i(reg_pc),
    .off_i(off), .step_i(step), .adj_i(adj), .adj_up_i(adj_up), .adj_pre_i(adj_pre),
    .ea_o(ea_c), .base_o(base_c), .wr_o(wr_c)
  );

  assign req_ready = (st == T_IDLE);
  assign res_valid = (st == T_DONE);
  assign accept    = req_valid && req_ready;

  ea_ptr_fetch #(.AW(AW), .DW(DW)) u_pf (
    .clk(clk), .rst_n(rst_n), .start_i(accept && ind), .addr_i(ea_c),
    .done_o(pf_done), .ptr_o(ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= T_IDLE;
      res_ea      <= '0;
      res_base    <= '0;
      res_base_wr <= 1'b0;
      res_err     <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (accept) begin
          res_base    <= base_c;
          res_base_wr <= wr_c;
          res_err     <= bad;
          if (ind) begin
            st <= T_IND;
          end else begin
            res_ea <= ea_c;
            st     <= T_DONE;
          end
        end
        T_IND:  if (pf_done) begin res_ea <= ptr; st <= T_DONE; end
        T_DONE: if (res_ready) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ea) && $stable(res_base)
      && $stable(res_base_wr) && $stable(res_err));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  p_err_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> !res_base_wr);

  p_mem_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != T_IND) |-> !mem_req_valid);
endmodule

// File: tb/sim_idx_ea_gen.sv
module sim_idx_ea_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  sel;
    logic [15:0] off;
    logic [15:0] ea;
    logic [15:0] bu;
    logic        wr;
    logic        err;
    logic        ind;
    logic [7:0]  req;
  } vec_t;

  // Registers fixed for the table: X=1234 Y=1000 SP=0A00 PC=C000 A=12 B=F0
  // Memory byte at address a is a[7:0]^5A.
  localparam vec_t VECS [NV] = '{
    '{4'd0,  2'd0, 16'h000A, 16'h123E, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 +10
    '{4'd0,  2'd1, 16'h0010, 16'h0FF0, 16'h1000, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 -16, R10 Y
    '{4'd1,  2'd2, 16'h01F6, 16'h09F6, 16'h0A00, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 -10
    '{4'd1,  2'd0, 16'h00FF, 16'h1333, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 +255
    '{4'd2,  2'd2, 16'hFFF6, 16'h09F6, 16'h0A00, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 SP-10
    '{4'd2,  2'd3, 16'h4000, 16'h0000, 16'hC000, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 wrap, R10 PC
    '{4'd3,  2'd0, 16'h0007, 16'h123C, 16'h123C, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 pre +8
    '{4'd4,  2'd1, 16'h0000, 16'h0FFF, 16'h0FFF, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 pre -1
    '{4'd5,  2'd2, 16'h0003, 16'h0A00, 16'h0A04, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 post +4
    '{4'd6,  2'd3, 16'hFFF9, 16'hC000, 16'hBFFE, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 post -2, upper bits ignored
    '{4'd7,  2'd0, 16'h0000, 16'h1246, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 A
    '{4'd8,  2'd1, 16'h0000, 16'h10F0, 16'h1000, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 B zero-extended
    '{4'd9,  2'd2, 16'h0000, 16'h1CF0, 16'h0A00, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 D
    '{4'd12, 2'd0, 16'h0005, 16'h1234, 16'h1234, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{4'd15, 2'd3, 16'h0005, 16'hC000, 16'hC000, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{4'd10, 2'd0, 16'h000A, 16'h6465, 16'h1234, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 [n,X]
    '{4'd11, 2'd1, 16'h0000, 16'hAAAB, 16'h1000, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 [D,Y]
    '{4'd10, 2'd3, 16'h3FFF, 16'hA55A, 16'hC000, 1'b0, 1'b0, 1'b1, 8'd7}   // R7 pointer wraps
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, res_ready = 1'b0;
  logic [3:0] req_mode = '0;
  logic [1:0] req_base_sel = '0;
  logic [15:0] req_offset = '0;
  logic [15:0] reg_x = 16'h1234, reg_y = 16'h1000, reg_sp = 16'h0A00, reg_pc = 16'hC000;
  logic [7:0] acc_a = 8'h12, acc_b = 8'hF0;
  logic req_ready, res_valid, res_base_wr, res_err, mem_req_valid;
  logic [15:0] res_ea, res_base, mem_addr;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = '0;
  int n_chk = 0, n_bad = 0, mem_reads = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_gen u0 (.*);

  // Memory model: ready on alternate cycles, reply one cycle after acceptance.
  always @(posedge clk) begin
    mem_req_ready <= rst_n ? ~mem_req_ready : 1'b0;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_addr[7:0] ^ 8'h5A;
    if (mem_req_valid && mem_req_ready) mem_reads <= mem_reads + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int cyc;
    int reads0;
    reads0 = mem_reads;
    @(negedge clk);
    req_mode = v.mode; req_base_sel = v.sel; req_offset = v.off; req_valid = 1'b1;
    cyc = 0;
    while (!req_ready && cyc < 200) begin @(negedge clk); cyc++; end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!res_valid && cyc < 200) begin @(negedge clk); cyc++; end
    if (!v.ind) chk(cyc == 1, "R11 latency", cyc, 1);
    chk(!req_ready, "R11 ready low while result pending", req_ready, 0);
    @(negedge clk);
    chk(res_valid, "R11 result held", res_valid, 1);
    chk(res_ea == v.ea, $sformatf("R%0d ea mode %0d", v.req, v.mode), res_ea, v.ea);
    chk(res_base == v.bu, $sformatf("R%0d base mode %0d", v.req, v.mode), res_base, v.bu);
    chk(res_base_wr == v.wr, $sformatf("R%0d/R9 write-back mode %0d", v.req, v.mode), res_base_wr, v.wr);
    chk(res_err == v.err, $sformatf("R%0d/R9 err mode %0d", v.req, v.mode), res_err, v.err);
    chk((mem_reads - reads0) == (v.ind ? 2 : 0), "R12 memory read count", mem_reads - reads0, v.ind ? 2 : 0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, "R11 result taken", {res_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(req_ready == 1'b1, "R13 req_ready", req_ready, 1);
    chk(res_valid == 1'b0, "R13 res_valid", res_valid, 0);
    chk(mem_req_valid == 1'b0, "R13 mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R10 X base with same offset, R1 +15 upper boundary
    run_vec('{4'd0, 2'd0, 16'h000F, 16'h1243, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd10});
    // R6 D with changed accumulators: 80:01 added to X
    acc_a = 8'h80; acc_b = 8'h01;
    run_vec('{4'd9, 2'd0, 16'h0000, 16'h9235, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd6});
    // R2 -256 lower boundary on SP
    run_vec('{4'd1, 2'd2, 16'h0100, 16'h0900, 16'h0A00, 1'b0, 1'b0, 1'b0, 8'd2});
    // R4 pre-decrement wrapping below zero
    reg_y = 16'h0003;
    run_vec('{4'd4, 2'd1, 16'h0007, 16'hFFFB, 16'hFFFB, 1'b1, 1'b0, 1'b0, 8'd4});
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule